// File: doc/BRIEF.md
# PLL Divider Search Engine

This block chooses the integer settings of a frequency synthesizer. Given a reference frequency and a wanted output frequency, both in whole kHz, it walks every legal pre-divider N. For each N it derives a feedback multiplier M, makes M even, works out the resulting oscillator frequency, and keeps the pair whose frequency comes nearest to the wanted value. Only pairs that keep the comparison frequency Fref/N inside 5..40 MHz and the oscillator inside 80..1000 MHz are considered.

A request is made by pulsing `start` with both frequencies on the inputs; the block samples them in that cycle. It then runs for a number of cycles that grows with the count of legal N values. All divisions share one shift-and-subtract divider that produces one quotient bit per cycle. When the search ends, `done` pulses for one cycle. At that point the best N, the best M, the oscillator frequency in kHz, the rounded-up rate in MHz and a found flag are valid. They stay valid until the next accepted request.

Top module: `pllsrch_top`

## Requirements
- R1: A `start` pulse while `busy` is low captures `refKhz` and `targetKhz` and raises `busy` on the next cycle. `done` is a single-cycle pulse that ends the search, and `busy` falls in the cycle after it. A `start` pulse while `busy` is high is ignored: it changes neither the result nor the number of `done` pulses.
- R2: N takes only values from max(1, ceil(Fref/40000)) to floor(Fref/5000) inclusive. A reference below 5000 kHz therefore gives no candidate.
- R3: For each N the candidate multiplier is floor(Fout·N/Fref). A candidate below 6 or above 512 is skipped.
- R4: An odd candidate multiplier is increased by one before it is evaluated.
- R5: The oscillator frequency is floor(M·Fref/N) kHz. A pair is rejected unless this value lies in 80000..1000000 kHz, both ends included.
- R6: The pair with the strictly smallest |Fout − Fosc| is reported. On equal error the smaller N is kept.
- R7: When no pair passes, `found` is 0 and `bestN`, `bestM`, `vcoKhz` and `rateMhz` are all 0 at `done`.
- R8: `rateMhz` equals ceil(`vcoKhz`/1000).
- R9: From `done` until the next accepted `start`, all result outputs hold their values even when the frequency inputs change.
- R10: After reset, `busy`, `done`, `found` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| refKhz | input | FREQ_W | Reference frequency in kHz |
| targetKhz | input | FREQ_W | Wanted output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A legal pair was found |
| bestN | output | N_W | Chosen pre-divider |
| bestM | output | M_W | Chosen even feedback multiplier |
| vcoKhz | output | FREQ_W | Oscillator frequency of the chosen pair, kHz |
| rateMhz | output | FREQ_W | Oscillator frequency rounded up to whole MHz |

## Verification
Most internal faults show up at the single `done` pulse of the affected request, as a wrong N, M, frequency or found flag. Examples are a wrong N bound, a mis-latched quotient, a missing even rounding or a wrong tie rule. The bench compares every completion against an independent model and against hand-worked corner cases, so such a fault shows within one search. A control fault that drops or repeats a search shows as a missing or extra `done` pulse within a few hundred cycles. A fault in result holding shows while the block is idle and its inputs change.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  typedef enum logic [2:0] {
    OP_NMIN  = 3'd0,
    OP_NMAX  = 3'd1,
    OP_MCAND = 3'd2,
    OP_VCO   = 3'd3,
    OP_RATE  = 3'd4
  } divOpE;

  typedef struct packed {
    logic  capture;
    logic  divGo;
    divOpE divOp;
    logic  takeNmin;
    logic  takeNmax;
    logic  takeM;
    logic  takeVco;
    logic  stepN;
    logic  takeRate;
  } ctrlStrobesT;

  typedef struct packed {
    logic divDone;
    logic haveN;
    logic mInRange;
    logic lastN;
    logic found;
  } dpStatusT;

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int NUM_W = 36,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remR;
  logic [DEN_W-1:0] denR;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [DEN_W:0]   trial;
  logic             fits;

  always_comb begin
    trial = {remR, quo[NUM_W-1]};
    fits  = trial >= {1'b0, denR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR    <= '0;
      denR    <= '0;
      quo     <= '0;
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (go) begin
      remR    <= '0;
      denR    <= den;
      quo     <= num;
      cnt     <= CNT_W'(NUM_W);
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running) begin
      if (fits) begin
        remR <= DEN_W'(trial - {1'b0, denR});
        quo  <= {quo[NUM_W-2:0], 1'b1};
      end else begin
        remR <= trial[DEN_W-1:0];
        quo  <= {quo[NUM_W-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/pllsrch_dp.sv
module pllsrch_dp
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W      = 24,
  parameter int N_W         = 12,
  parameter int M_W         = 10,
  parameter int PFD_MIN_KHZ = 5000,
  parameter int PFD_MAX_KHZ = 40000,
  parameter int VCO_MIN_KHZ = 80000,
  parameter int VCO_MAX_KHZ = 1000000,
  parameter int M_MIN       = 6,
  parameter int M_MAX       = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       ctrl,
  input  logic [FREQ_W-1:0] refKhz,
  input  logic [FREQ_W-1:0] targetKhz,
  output dpStatusT          status,
  output logic [N_W-1:0]    bestN,
  output logic [M_W-1:0]    bestM,
  output logic [FREQ_W-1:0] vcoKhz,
  output logic [FREQ_W-1:0] rateMhz
);
  localparam int DIV_W = FREQ_W + N_W;
  localparam logic [N_W-1:0] N_CAP = {{(N_W-1){1'b1}}, 1'b0};

  logic [FREQ_W-1:0] refR, tgtR, bestErr;
  logic [N_W-1:0]    nCur, nMax;
  logic [M_W-1:0]    mCur;
  logic              foundR;

  logic [DIV_W-1:0]  divNum, quo;
  logic [FREQ_W-1:0] divDen;
  logic              divDone;

  logic              vcoOk, better;
  logic [FREQ_W-1:0] candVco, candErr;

  always_comb begin
    divNum = '0;
    divDen = '0;
    unique case (ctrl.divOp)
      OP_NMIN: begin
        divNum = DIV_W'(refR) + DIV_W'(PFD_MAX_KHZ - 1);
        divDen = FREQ_W'(PFD_MAX_KHZ);
      end
      OP_NMAX: begin
        divNum = DIV_W'(refR);
        divDen = FREQ_W'(PFD_MIN_KHZ);
      end
      OP_MCAND: begin
        divNum = DIV_W'(tgtR) * DIV_W'(nCur);
        divDen = refR;
      end
      OP_VCO: begin
        divNum = DIV_W'(mCur) * DIV_W'(refR);
        divDen = FREQ_W'(nCur);
      end
      OP_RATE: begin
        divNum = DIV_W'(vcoKhz) + DIV_W'(999);
        divDen = FREQ_W'(1000);
      end
      default: ;
    endcase
  end

  pllsrch_div #(.NUM_W(DIV_W), .DEN_W(FREQ_W)) u_div (
    .clk  (clk),
    .rstN (rstN),
    .go   (ctrl.divGo),
    .num  (divNum),
    .den  (divDen),
    .done (divDone),
    .quo  (quo)
  );

  always_comb begin
    candVco = FREQ_W'(quo);
    vcoOk   = (quo >= DIV_W'(VCO_MIN_KHZ)) && (quo <= DIV_W'(VCO_MAX_KHZ));
    candErr = (tgtR >= candVco) ? (tgtR - candVco) : (candVco - tgtR);
    better  = !foundR || (candErr < bestErr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refR    <= '0;
      tgtR    <= '0;
      nCur    <= '0;
      nMax    <= '0;
      mCur    <= '0;
      foundR  <= 1'b0;
      bestN   <= '0;
      bestM   <= '0;
      vcoKhz  <= '0;
      bestErr <= '0;
      rateMhz <= '0;
    end else begin
      if (ctrl.capture) begin
        refR    <= refKhz;
        tgtR    <= targetKhz;
        foundR  <= 1'b0;
        bestN   <= '0;
        bestM   <= '0;
        vcoKhz  <= '0;
        bestErr <= '0;
        rateMhz <= '0;
      end
      if (ctrl.takeNmin) begin
        if (quo == '0)                  nCur <= N_W'(1);
        else if (quo > DIV_W'(N_CAP))   nCur <= N_CAP;
        else                            nCur <= N_W'(quo);
      end
      if (ctrl.takeNmax) begin
        if (quo > DIV_W'(N_CAP)) nMax <= N_CAP;
        else                     nMax <= N_W'(quo);
      end
      if (ctrl.takeM) begin
        mCur <= M_W'(quo) + M_W'(quo[0]);
      end
      if (ctrl.takeVco && vcoOk && better) begin
        foundR  <= 1'b1;
        bestN   <= nCur;
        bestM   <= mCur;
        vcoKhz  <= candVco;
        bestErr <= candErr;
      end
      if (ctrl.stepN) begin
        nCur <= nCur + 1'b1;
      end
      if (ctrl.takeRate) begin
        rateMhz <= FREQ_W'(quo);
      end
    end
  end

  always_comb begin
    status.divDone  = divDone;
    status.haveN    = nCur <= nMax;
    status.mInRange = (quo >= DIV_W'(M_MIN)) && (quo <= DIV_W'(M_MAX));
    status.lastN    = nCur == nMax;
    status.found    = foundR;
  end
endmodule

// File: rtl/pllsrch_ctrl.sv
module pllsrch_ctrl
  import pllsrch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatusT    status,
  output ctrlStrobesT ctrl,
  output logic        busy,
  output logic        done
);
  typedef enum logic [3:0] {
    S_IDLE, S_BOUNDS, S_NMIN, S_NMAX, S_CHECK, S_MCAND,
    S_VCOGO, S_VCO, S_NEXT, S_WRAP, S_RATE, S_FINISH
  } stateE;

  stateE state, nxt;

  always_comb begin
    ctrl       = '0;
    ctrl.divOp = OP_NMIN;
    nxt        = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctrl.capture = 1'b1;
        nxt = S_BOUNDS;
      end
      S_BOUNDS: begin
        ctrl.divGo = 1'b1;
        ctrl.divOp = OP_NMIN;
        nxt = S_NMIN;
      end
      S_NMIN: if (status.divDone) begin
        ctrl.takeNmin = 1'b1;
        ctrl.divGo    = 1'b1;
        ctrl.divOp    = OP_NMAX;
        nxt = S_NMAX;
      end
      S_NMAX: if (status.divDone) begin
        ctrl.takeNmax = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: if (status.haveN) begin
        ctrl.divGo = 1'b1;
        ctrl.divOp = OP_MCAND;
        nxt = S_MCAND;
      end else begin
        nxt = S_WRAP;
      end
      S_MCAND: if (status.divDone) begin
        if (status.mInRange) begin
          ctrl.takeM = 1'b1;
          nxt = S_VCOGO;
        end else begin
          nxt = S_NEXT;
        end
      end
      S_VCOGO: begin
        ctrl.divGo = 1'b1;
        ctrl.divOp = OP_VCO;
        nxt = S_VCO;
      end
      S_VCO: if (status.divDone) begin
        ctrl.takeVco = 1'b1;
        nxt = S_NEXT;
      end
      S_NEXT: if (status.lastN) begin
        nxt = S_WRAP;
      end else begin
        ctrl.stepN = 1'b1;
        nxt = S_CHECK;
      end
      S_WRAP: if (status.found) begin
        ctrl.divGo = 1'b1;
        ctrl.divOp = OP_RATE;
        nxt = S_RATE;
      end else begin
        nxt = S_FINISH;
      end
      S_RATE: if (status.divDone) begin
        ctrl.takeRate = 1'b1;
        nxt = S_FINISH;
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = state != S_IDLE;
  assign done = state == S_FINISH;
endmodule

// File: rtl/pllsrch_top.sv
module pllsrch_top
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W      = 24,
  parameter int N_W         = 12,
  parameter int M_W         = 10,
  parameter int PFD_MIN_KHZ = 5000,
  parameter int PFD_MAX_KHZ = 40000,
  parameter int VCO_MIN_KHZ = 80000,
  parameter int VCO_MAX_KHZ = 1000000,
  parameter int M_MIN       = 6,
  parameter int M_MAX       = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] refKhz,
  input  logic [FREQ_W-1:0] targetKhz,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [N_W-1:0]    bestN,
  output logic [M_W-1:0]    bestM,
  output logic [FREQ_W-1:0] vcoKhz,
  output logic [FREQ_W-1:0] rateMhz
);
  ctrlStrobesT ctrl;
  dpStatusT    status;

  pllsrch_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .ctrl   (ctrl),
    .busy   (busy),
    .done   (done)
  );

  pllsrch_dp #(
    .FREQ_W(FREQ_W), .N_W(N_W), .M_W(M_W),
    .PFD_MIN_KHZ(PFD_MIN_KHZ), .PFD_MAX_KHZ(PFD_MAX_KHZ),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .M_MIN(M_MIN), .M_MAX(M_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .refKhz    (refKhz),
    .targetKhz (targetKhz),
    .status    (status),
    .bestN     (bestN),
    .bestM     (bestM),
    .vcoKhz    (vcoKhz),
    .rateMhz   (rateMhz)
  );

  assign found = status.found;
endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
  parameter int FREQ_W      = 24,
  parameter int N_W         = 12,
  parameter int M_W         = 10,
  parameter int VCO_MIN_KHZ = 80000,
  parameter int VCO_MAX_KHZ = 1000000,
  parameter int M_MIN       = 6,
  parameter int M_MAX       = 512
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic [N_W-1:0]    bestN,
  input logic [M_W-1:0]    bestM,
  input logic [FREQ_W-1:0] vcoKhz,
  input logic [FREQ_W-1:0] rateMhz
);
  localparam int W2 = FREQ_W + 11;

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_done_in_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_m_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (bestM >= M_W'(M_MIN) && bestM <= M_W'(M_MAX)));

  p_m_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> !bestM[0]);

  p_vco_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (vcoKhz >= FREQ_W'(VCO_MIN_KHZ) && vcoKhz <= FREQ_W'(VCO_MAX_KHZ)));

  p_none_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !found) |-> (bestN == '0 && bestM == '0 && vcoKhz == '0 && rateMhz == '0));

  p_rate_ceil_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> ((W2'(rateMhz) * W2'(1000) >= W2'(vcoKhz)) &&
                         (W2'(rateMhz) * W2'(1000) <  W2'(vcoKhz) + W2'(1000))));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(found) && $stable(bestN) && $stable(bestM) &&
                          $stable(vcoKhz) && $stable(rateMhz)));
endmodule

bind pllsrch_top pllsrch_chk #(
  .FREQ_W(FREQ_W), .N_W(N_W), .M_W(M_W),
  .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
  .M_MIN(M_MIN), .M_MAX(M_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .found(found), .bestN(bestN), .bestM(bestM), .vcoKhz(vcoKhz), .rateMhz(rateMhz)
);

// File: tb/pllsrch_top_test.sv
module pllsrch_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W = 24;
  localparam int N_W = 12;
  localparam int M_W = 10;

  typedef struct {
    bit      found;
    longint  n, m, vco, rate;
    string   req;
  } expT;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [FREQ_W-1:0] refIn = '0, tgtIn = '0;
  logic busy, done, found;
  logic [N_W-1:0] bestN;
  logic [M_W-1:0] bestM;
  logic [FREQ_W-1:0] vcoKhz, rateMhz;

  int checks = 0, errors = 0;
  bit reported = 0;
  expT expQ[$];
  expT lastExp, monE;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllsrch_top uut (
    .clk(clk), .rstN(rstN), .start(start), .refKhz(refIn), .targetKhz(tgtIn),
    .busy(busy), .done(done), .found(found), .bestN(bestN), .bestM(bestM),
    .vcoKhz(vcoKhz), .rateMhz(rateMhz)
  );

  function automatic expT model(longint fref, longint fout, string req);
    expT r;
    longint nlo, nhi, bestErr, m, v, err;
    r.found = 0; r.n = 0; r.m = 0; r.vco = 0; r.rate = 0; r.req = req;
    bestErr = 0;
    nlo = (fref + 39999) / 40000;
    if (nlo < 1) nlo = 1;
    nhi = fref / 5000;
    for (longint n = nlo; n <= nhi; n++) begin
      m = (fout * n) / fref;
      if (m < 6 || m > 512) continue;
      if (m % 2 == 1) m = m + 1;
      v = (m * fref) / n;
      if (v < 80000 || v > 1000000) continue;
      err = (fout >= v) ? fout - v : v - fout;
      if (!r.found || err < bestErr) begin
        r.found = 1; r.n = n; r.m = m; r.vco = v; bestErr = err;
      end
    end
    if (r.found) r.rate = (r.vco + 999) / 1000;
    return r;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected results on every done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected done pulse, actual done=1 expected no completion");
      end else begin
        monE = expQ.pop_front();
        lastExp = monE;
        if (found !== monE.found || bestN !== N_W'(monE.n) || bestM !== M_W'(monE.m) ||
            vcoKhz !== FREQ_W'(monE.vco) || rateMhz !== FREQ_W'(monE.rate)) begin
          errors++;
          $display("FAIL %s: actual found=%0d N=%0d M=%0d vco=%0d rate=%0d expected found=%0d N=%0d M=%0d vco=%0d rate=%0d",
                   monE.req, found, bestN, bestM, vcoKhz, rateMhz,
                   monE.found, monE.n, monE.m, monE.vco, monE.rate);
        end
      end
    end
  end

  task automatic launch(longint fref, longint fout);
    @(negedge clk);
    while (busy) @(negedge clk);
    refIn = FREQ_W'(fref); tgtIn = FREQ_W'(fout); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (busy !== 1'b1) begin
      errors++;
      $display("FAIL R1: busy after start, actual %0d expected 1", busy);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R1: busy after done, actual %0d expected 0", busy);
    end
  endtask

  task automatic runModel(longint fref, longint fout, string req);
    expQ.push_back(model(fref, fout, req));
    launch(fref, fout);
    drain();
  endtask

  task automatic runKnown(longint fref, longint fout, bit f, longint n, longint m,
                          longint v, longint r, string req);
    expT e;
    e.found = f; e.n = n; e.m = m; e.vco = v; e.rate = r; e.req = req;
    expQ.push_back(e);
    launch(fref, fout);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still going, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    checks++;
    if (busy !== 0 || done !== 0 || found !== 0 || bestN !== 0 || bestM !== 0 ||
        vcoKhz !== 0 || rateMhz !== 0) begin
      errors++;
      $display("FAIL R10: actual busy=%0d done=%0d found=%0d N=%0d M=%0d expected all 0",
               busy, done, found, bestN, bestM);
    end

    runKnown(24000, 1000000, 1, 4, 166, 996000, 996, "R5 upper vco rejects small N");
    runKnown(20000, 80000,   1, 2, 8,   80000,  80,  "R5 lower vco edge inclusive");
    runKnown(10000, 995000,  1, 1, 100, 1000000, 1000, "R2 upper N bound and R6 tie");
    runKnown(41000, 410000,  1, 2, 20,  410000, 410, "R2 lower N bound");
    runKnown(24000, 480000,  1, 1, 20,  480000, 480, "R6 tie keeps smaller N");
    runKnown(24000, 318000,  1, 3, 40,  320000, 320, "R4 odd M rounded up");
    runKnown(25000, 417000,  1, 3, 50,  416666, 417, "R8 rate rounded up");
    runKnown(24000, 50000,   0, 0, 0, 0, 0, "R7 nothing passes");
    runKnown(5000,  3000000, 0, 0, 0, 0, 0, "R3 M above limit skipped");
    runKnown(4000,  500000,  0, 0, 0, 0, 0, "R2 reference below PFD floor");

    runModel(24000, 500000,  "R6 sweep a");
    runModel(27000, 333333,  "R3 sweep b");
    runModel(200000, 999000, "R2 sweep c");
    runModel(38400, 812345,  "R5 sweep d");
    runModel(150000, 120000, "R6 sweep e");

    // R1: start during busy is ignored
    expQ.push_back(model(24000, 300000, "R1 start while busy ignored"));
    launch(24000, 300000);
    repeat (5) @(negedge clk);
    refIn = 25000; tgtIn = 417000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (300) @(negedge clk);

    // R9: results hold while idle with changing inputs
    refIn = 99999; tgtIn = 12345;
    repeat (20) @(negedge clk);
    checks++;
    if (found !== lastExp.found || bestN !== N_W'(lastExp.n) || bestM !== M_W'(lastExp.m) ||
        vcoKhz !== FREQ_W'(lastExp.vco) || rateMhz !== FREQ_W'(lastExp.rate)) begin
      errors++;
      $display("FAIL R9: actual N=%0d M=%0d vco=%0d expected N=%0d M=%0d vco=%0d",
               bestN, bestM, vcoKhz, lastExp.n, lastExp.m, lastExp.vco);
    end

    report();
  end
endmodule